// File: doc/BRIEF.md
# Programmable Clock Output Divider with Reset Stretcher

This block derives a host-selectable clock output from the oscillator clock and conditions the external reset for the rest of the controller. A 3-bit select code chooses the ratio. Code 7 passes the oscillator straight through. Codes 0 to 6 divide by an even factor from 2 to 14. A separate off bit parks the output low, which reduces emissions when nothing uses the clock.

The external reset is asynchronous and active low. When it is driven low, the internal reset asserts at once. When the pin is released, the release first crosses a two-stage synchronizer and then waits fifteen oscillator clocks before the internal reset drops. While the internal reset is high, the divider setting returns to a default chosen by the interface-mode pin. A high pin gives divide-by-2. A low pin gives divide-by-12. The off bit is cleared.

A setting written by the host is only staged at first. The output picks it up at its next rising edge, so a period in progress always completes with its old length.

Top module: `clkout_unit`

## Requirements
- R1: The output period equals the factor picked by the select code: code 7 gives 1, and a code c from 0 to 6 gives 2*(c+1) oscillator cycles.
- R2: For any factor of 2 or more, the output is high for exactly factor/2 cycles and then low for factor/2 cycles.
- R3: With factor 1 the output follows the oscillator clock: it is high in the high phase and low in the low phase.
- R4: With the off bit at 1, the output stays low from its next period boundary on, whatever the factor.
- R5: A write (cfg_we_i high at a rising clock edge) is applied only at the next rising edge of the output. The period in progress completes with the old high and low lengths.
- R6: A low level on ext_rst_ni sets sys_rst_o high at once, without waiting for a clock edge.
- R7: After ext_rst_ni rises between clock edges, sys_rst_o stays high and falls at the 17th rising clock edge that follows (2 synchronizer stages plus 15 stretch cycles). After that it stays low until the next external reset.
- R8: While sys_rst_o is high, the setting is forced to its default: factor 2 (code 0) if bus_mode_i is 1, factor 12 (code 5) if bus_mode_i is 0, and the off bit 0. Writes made during this time are ignored.
- R9: From the first clock edge after sys_rst_o is high until it falls, clk_out_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| ext_rst_ni | input | 1 | Asynchronous external reset, active low |
| bus_mode_i | input | 1 | Interface-mode pin; selects the reset default ratio |
| cfg_we_i | input | 1 | Write strobe for the divider setting |
| cfg_sel_i | input | 3 | Select code: 7 gives divide-by-1, c from 0 to 6 gives divide-by-2*(c+1) |
| cfg_off_i | input | 1 | Clock-off bit; 1 parks the output low |
| clk_out_o | output | 1 | Divided clock output |
| sys_rst_o | output | 1 | Stretched internal reset, active high |

## Verification
Two situations are the hardest to reach from the ports.

The first is a write that lands partway through a long period. The bench waits for a rising edge of the output while divide-by-14 runs, then writes divide-by-2. It then measures that the 7-high/7-low period still completes before the fast ratio appears.

The second is a write made while the internal reset is still stretching. The bench does this with the mode pin low, and after release it expects the divide-by-12 default rather than the written value.

A behavioural model, advanced on every edge, checks both clock phases throughout, including the switches into and out of pass-through.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
    localparam int SEL_W = 3;
    typedef logic [SEL_W-1:0] sel_t;
    // all-ones code selects pass-through (divide-by-1)
    localparam sel_t SEL_BYPASS = '1;
endpackage

// File: rtl/clkout_rst_stretch.sv
module clkout_rst_stretch #(
    parameter int SYNC_STAGES = 2,
    parameter int STRETCH     = 15
) (
    input  logic clk_i,
    input  logic arst_ni,
    output logic rst_o
);
    localparam int CNT_W = $clog2(STRETCH + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   rst;
    } stretch_t;

    stretch_t d, q;

    always_comb begin
        d = q;
        d.sync = (q.sync << 1) | SYNC_STAGES'(1);
        if (q.sync[SYNC_STAGES-1] && (q.cnt != CNT_W'(STRETCH))) begin
            d.cnt = q.cnt + 1'b1;
        end
        d.rst = (d.cnt != CNT_W'(STRETCH));
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            q <= '{sync: '0, cnt: '0, rst: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign rst_o = q.rst;

    // R7
    rel_after_sync_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $fell(q.rst) |-> $past(q.sync[SYNC_STAGES-1]));

    // R7
    rel_sticky_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        !q.rst |=> !q.rst);
endmodule

// File: rtl/clkout_cfg.sv
module clkout_cfg
    import clkout_pkg::*;
#(
    parameter sel_t DEF_SEL_HI = sel_t'(0),
    parameter sel_t DEF_SEL_LO = sel_t'(5)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mode_i,
    input  logic we_i,
    input  sel_t sel_i,
    input  logic off_i,
    output sel_t sel_o,
    output logic off_o,
    output sel_t def_sel_o
);
    typedef struct packed {
        sel_t sel;
        logic off;
    } cfg_t;

    cfg_t d, q;

    assign def_sel_o = mode_i ? DEF_SEL_HI : DEF_SEL_LO;

    always_comb begin
        d = q;
        if (rst_i) begin
            d.sel = def_sel_o;
            d.off = 1'b0;
        end else if (we_i) begin
            d.sel = sel_i;
            d.off = off_i;
        end
    end

    always_ff @(posedge clk_i) begin
        q <= d;
    end

    assign sel_o = q.sel;
    assign off_o = q.off;
endmodule

// File: rtl/clkout_div_core.sv
module clkout_div_core
    import clkout_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  sel_t def_sel_i,
    input  sel_t cfg_sel_i,
    input  logic cfg_off_i,
    output logic phase_o,
    output logic clk_out_o
);
    // half: cycles per half period; cnt: position inside the half
    typedef struct packed {
        sel_t half;
        sel_t cnt;
        logic phase;
        logic byp;
        logic off;
    } core_t;

    core_t d, q;
    logic  last, start, new_byp;

    always_comb begin
        d       = q;
        last    = (q.cnt == (q.half - sel_t'(1)));
        start   = q.byp || (!q.phase && last);
        new_byp = (cfg_sel_i == SEL_BYPASS);
        if (rst_i) begin
            d.half  = def_sel_i + sel_t'(1);
            d.cnt   = '0;
            d.phase = 1'b0;
            d.byp   = 1'b0;
            d.off   = 1'b0;
        end else if (start) begin
            // period boundary: staged setting becomes active
            d.half  = new_byp ? sel_t'(1) : (cfg_sel_i + sel_t'(1));
            d.byp   = new_byp;
            d.off   = cfg_off_i;
            d.cnt   = '0;
            d.phase = !new_byp;
        end else if (last) begin
            d.phase = 1'b0;
            d.cnt   = '0;
        end else begin
            d.cnt = q.cnt + sel_t'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        q <= d;
    end

    assign phase_o   = q.phase;
    assign clk_out_o = (q.byp ? clk_i : q.phase) & ~q.off;

    // R2
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !q.byp |-> (q.cnt < q.half));

    // R5
    hold_between_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !start |=> $stable({q.half, q.byp, q.off}));

    // R3
    bypass_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        q.byp |-> (!q.phase && (q.cnt == '0)));
endmodule

// File: rtl/clkout_unit.sv
module clkout_unit
    import clkout_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter int   STRETCH     = 15,
    parameter sel_t DEF_SEL_HI  = sel_t'(0),
    parameter sel_t DEF_SEL_LO  = sel_t'(5)
) (
    input  logic             clk_i,
    input  logic             ext_rst_ni,
    input  logic             bus_mode_i,
    input  logic             cfg_we_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    input  logic             cfg_off_i,
    output logic             clk_out_o,
    output logic             sys_rst_o
);
    sel_t cfg_sel, def_sel;
    logic cfg_off, core_phase;

    clkout_rst_stretch #(
        .SYNC_STAGES(SYNC_STAGES),
        .STRETCH    (STRETCH)
    ) u_rst (
        .clk_i  (clk_i),
        .arst_ni(ext_rst_ni),
        .rst_o  (sys_rst_o)
    );

    clkout_cfg #(
        .DEF_SEL_HI(DEF_SEL_HI),
        .DEF_SEL_LO(DEF_SEL_LO)
    ) u_cfg (
        .clk_i    (clk_i),
        .rst_i    (sys_rst_o),
        .mode_i   (bus_mode_i),
        .we_i     (cfg_we_i),
        .sel_i    (cfg_sel_i),
        .off_i    (cfg_off_i),
        .sel_o    (cfg_sel),
        .off_o    (cfg_off),
        .def_sel_o(def_sel)
    );

    clkout_div_core u_core (
        .clk_i    (clk_i),
        .rst_i    (sys_rst_o),
        .def_sel_i(def_sel),
        .cfg_sel_i(cfg_sel),
        .cfg_off_i(cfg_off),
        .phase_o  (core_phase),
        .clk_out_o(clk_out_o)
    );

    // R8
    rst_default_chk: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
        sys_rst_o |=> ((cfg_sel == $past(def_sel)) && !cfg_off));

    // R9
    rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
        sys_rst_o |=> !core_phase);
endmodule

// File: tb/tb_clkout_unit.sv
module tb_clkout_unit;
    logic       clk = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       bus_mode = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = 3'd0;
    logic       cfg_off = 1'b0;
    logic       clk_out, sys_rst;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clkout_unit dut (
        .clk_i     (clk),
        .ext_rst_ni(ext_rst_n),
        .bus_mode_i(bus_mode),
        .cfg_we_i  (cfg_we),
        .cfg_sel_i (cfg_sel),
        .cfg_off_i (cfg_off),
        .clk_out_o (clk_out),
        .sys_rst_o (sys_rst)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: factors as integers, position t inside the period
    int m_rcnt = 0;
    bit m_rst = 1'b1;
    int m_pf = 2, m_af = 2, m_t = 1;
    bit m_po = 1'b0, m_ao = 1'b0;

    function automatic int code2factor(input logic [2:0] c);
        return (c == 3'd7) ? 1 : 2 * (int'(c) + 1);
    endfunction

    function automatic bit exp_hi();
        if (m_af == 1) return !m_ao;
        return (m_t < m_af / 2) && !m_ao;
    endfunction

    function automatic bit exp_lo();
        if (m_af == 1) return 1'b0;
        return (m_t < m_af / 2) && !m_ao;
    endfunction

    always @(negedge ext_rst_n) begin
        m_rst  = 1'b1;
        m_rcnt = 0;
    end

    always @(posedge clk) begin
        bit rst_prev;
        rst_prev = m_rst;
        if (!ext_rst_n) begin
            m_rcnt = 0;
            m_rst  = 1'b1;
        end else begin
            m_rcnt++;
            if (m_rcnt >= 17) m_rst = 1'b0;
        end
        if (rst_prev) begin
            m_pf = bus_mode ? 2 : 12;
            m_po = 1'b0;
            m_af = m_pf;
            m_ao = 1'b0;
            m_t  = m_af / 2;
        end else begin
            if (m_af == 1 || m_t == m_af - 1) begin
                m_af = m_pf;
                m_ao = m_po;
                m_t  = 0;
            end else begin
                m_t++;
            end
            if (cfg_we) begin
                m_pf = code2factor(cfg_sel);
                m_po = cfg_off;
            end
        end
    end

    // model comparison in both clock phases
    always @(posedge clk) begin
        #2;
        if (cmp_en) begin
            chk(clk_out === exp_hi(), "R1 model high phase clk_out", int'(clk_out), int'(exp_hi()));
            chk(sys_rst === m_rst, "R7 model sys_rst", int'(sys_rst), int'(m_rst));
        end
        #5;
        if (cmp_en) chk(clk_out === exp_lo(), "R3 model low phase clk_out", int'(clk_out), int'(exp_lo()));
    end

    task automatic wait_rise();
        bit prev;
        do begin
            prev = clk_out;
            @(posedge clk); #2;
        end while (!(prev == 1'b0 && clk_out == 1'b1));
    endtask

    task automatic run_len(input bit lvl, output int n);
        n = 0;
        while (clk_out === lvl && n < 100) begin
            n++;
            @(posedge clk); #2;
        end
    endtask

    task automatic measure(input int eh, input int el, input string tag);
        int h, l;
        wait_rise();
        run_len(1'b1, h);
        run_len(1'b0, l);
        chk(h == eh, {tag, " high length"}, h, eh);
        chk(l == el, {tag, " low length"}, l, el);
    endtask

    task automatic write_cfg(input logic [2:0] s, input bit off);
        cfg_we = 1'b1; cfg_sel = s; cfg_off = off;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n, h, l;
        #1 ext_rst_n = 1'b0;
        #1;
        chk(sys_rst === 1'b1, "R6 reset asserted before any edge", int'(sys_rst), 1);
        cycles(3);
        cmp_en = 1'b1;
        cycles(3);
        chk(sys_rst === 1'b1, "R6 reset held", int'(sys_rst), 1);
        chk(clk_out === 1'b0, "R9 output low in reset", int'(clk_out), 0);

        // release at mid-low; count edges until release
        #4 ext_rst_n = 1'b1;
        n = 0;
        do begin
            @(posedge clk); #2;
            n++;
        end while (sys_rst === 1'b1 && n < 40);
        chk(n == 17, "R7 release edge count", n, 17);

        // mode high default: divide-by-2
        measure(1, 1, "R8 mode-high default factor 2");

        // factor 12, 14, 6
        write_cfg(3'd5, 1'b0);
        cycles(4);
        measure(6, 6, "R1 code 5 factor 12");
        measure(6, 6, "R2 code 5 duty");
        write_cfg(3'd6, 1'b0);
        measure(7, 7, "R1 code 6 factor 14");
        write_cfg(3'd2, 1'b0);
        cycles(16);
        measure(3, 3, "R2 code 2 factor 6");

        // R5: change mid-period under factor 14
        write_cfg(3'd6, 1'b0);
        cycles(16);
        wait_rise();
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_off = 1'b0;
        run_len(1'b1, h);
        run_len(1'b0, l);
        cfg_we = 1'b0;
        chk(h == 7, "R5 old high length kept", h, 7);
        chk(l == 7, "R5 old low length kept", l, 7);
        run_len(1'b1, h);
        run_len(1'b0, l);
        chk(h == 1 && l == 1, "R5 new factor after boundary", h + l, 2);

        // R3: pass-through
        write_cfg(3'd7, 1'b0);
        cycles(4);
        for (int i = 0; i < 4; i++) begin
            chk(clk_out === 1'b1, "R3 bypass high phase", int'(clk_out), 1);
            #5;
            chk(clk_out === 1'b0, "R3 bypass low phase", int'(clk_out), 0);
            @(posedge clk); #2;
        end

        // R4: off in bypass and in divide-by-4
        write_cfg(3'd7, 1'b1);
        cycles(2);
        chk(clk_out === 1'b0, "R4 off in bypass", int'(clk_out), 0);
        write_cfg(3'd1, 1'b1);
        cycles(6);
        n = 0;
        for (int i = 0; i < 12; i++) begin
            if (clk_out !== 1'b0) n++;
            #5;
            if (clk_out !== 1'b0) n++;
            @(posedge clk); #2;
        end
        chk(n == 0, "R4 off holds output low", n, 0);
        write_cfg(3'd1, 1'b0);
        measure(2, 2, "R1 code 1 factor 4 after off cleared");

        // R8: mode low, writes during reset ignored; async assertion
        write_cfg(3'd6, 1'b0);
        cycles(3);
        #1 ext_rst_n = 1'b0;
        #1;
        chk(sys_rst === 1'b1, "R6 immediate async assertion", int'(sys_rst), 1);
        bus_mode = 1'b0;
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_sel = 3'd7; cfg_off = 1'b1;
        cycles(3);
        #4 ext_rst_n = 1'b1;
        @(posedge clk); #2;
        cycles(3);
        cfg_we = 1'b0;
        chk(clk_out === 1'b0, "R9 output low during stretch", int'(clk_out), 0);
        n = 4;
        while (sys_rst === 1'b1 && n < 40) begin
            @(posedge clk); #2;
            n++;
        end
        chk(n == 17, "R7 release edge count mode low", n, 17);
        measure(6, 6, "R8 mode-low default factor 12, writes ignored");

        cycles(2);
        finish_run();
    end
endmodule